// File: doc/BRIEF.md
# UART FIFO Register Front End

This block sits on a processor's word-wide memory-mapped bus and fronts a UART. It owns a transmit FIFO and a receive FIFO, both always in the data path. A bus read of the data register returns the byte at the head of the receive FIFO together with the empty and full flags of both FIFOs. A bus write to the same register carries the byte to transmit and two strobe bits. One strobe pushes that byte into the transmit FIFO. The other pops the receive FIFO. Either strobe, both or neither may be set in one write.

Three further registers can only be written. Two hold the transmit and receive baud divisors, which are programmed separately. The third holds the framing word. The serializer drains the transmit FIFO through a valid/take pair, and the deserializer fills the receive FIFO through a one-cycle valid strobe. Neither serializer nor deserializer is part of this block.

Top module: `uart_fifo_regs`

## Requirements
- R1: After reset both FIFOs are empty, a data read returns 0x0900, `tx_valid` is 0, both divisors equal CLK_HZ/BAUD (1085 by default), and `frame_cfg` is 0x84 (8 data bits, 1 stop bit, no parity).
- R2: A read at BASE+1 returns bits 7:0 = receive head byte, bit 8 = receive empty, bit 9 = receive full, bit 11 = transmit empty, bit 12 = transmit full. Bits 10 and 15:13 read 0.
- R3: A write at BASE+1 with bit 13 set pushes bits 7:0 into the transmit FIFO. `tx_valid` is high while that FIFO holds data, `tx_byte` shows its oldest entry, and `tx_take` with `tx_valid` high removes that entry. Bytes leave in the order they were pushed.
- R4: A push while the transmit FIFO holds DEPTH (8) entries is ignored, and the queued bytes are unchanged.
- R5: `rx_valid` pushes `rx_byte` into the receive FIFO. A write at BASE+1 with bit 10 set pops it. Bytes are read in arrival order, the full flag is set at DEPTH entries, and an arrival while full is dropped.
- R6: A pop while the receive FIFO is empty is ignored. The FIFO stays empty and the byte field of the data read is unchanged.
- R7: A push or pop made in one cycle is visible in the status flags and the head byte on the following cycle.
- R8: A write at BASE+2 loads the transmit divisor and a write at BASE+3 loads the receive divisor. Each write leaves the other divisor unchanged.
- R9: A write at BASE+4 loads wdata bits 7:0 into `frame_cfg`, which is laid out as bit 0 parity enable, bit 1 even parity, bits 3:2 stop-bit count and bits 7:4 data-bit count.
- R10: A read at BASE+2, BASE+3 or BASE+4 returns 0.
- R11: When a push and a pop of the same FIFO fall in one cycle, both take effect and the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Bus word address |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 16 | Bus write data |
| rdata | output | 16 | Bus read data (combinational) |
| tx_valid | output | 1 | Transmit FIFO holds a byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Serializer takes the oldest transmit byte |
| rx_valid | input | 1 | Deserializer delivers a byte |
| rx_byte | input | 8 | Received byte |
| tx_div | output | DIV_W | Transmit baud divisor |
| rx_div | output | DIV_W | Receive baud divisor |
| frame_cfg | output | 8 | Framing control word |

## Verification
Each FIFO has two independent sides, so a bus push and a serializer take can land in the same cycle on the transmit FIFO. The same holds for a deserializer arrival and a bus pop on the receive FIFO. The random phase drives both sides of each FIFO on every cycle with independent probabilities, which produces such collisions at empty, partly filled and full levels. A directed step forces one collision on the transmit side while it holds a single entry. A queue model in the bench judges each cycle: it gives a push priority only from the pre-cycle fill level, and it compares the flags, head bytes and `tx_valid` afterwards.

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs #(
  parameter int ADDR_W = 16,
  parameter int DIV_W = 16,
  parameter int DEPTH = 8,
  parameter int CLK_HZ = 125_000_000,
  parameter int BAUD = 115_200,
  parameter logic [ADDR_W-1:0] BASE = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_take,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [DIV_W-1:0]  tx_div,
  output logic [DIV_W-1:0]  rx_div,
  output logic [7:0]        frame_cfg
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [DIV_W-1:0] DEF_DIV = DIV_W'(CLK_HZ / BAUD);
  localparam logic [7:0] DEF_FRAME = 8'h84;
  localparam logic [ADDR_W-1:0] A_DATA = BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TXD  = BASE + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RXD  = BASE + ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CTL  = BASE + ADDR_W'(4);

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]   tx_cnt, rx_cnt;

  wire data_wr  = wr_en && addr == A_DATA;
  wire tx_full  = tx_cnt == FULL_CNT;
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == FULL_CNT;
  wire rx_empty = rx_cnt == '0;
  wire tx_push  = data_wr && wdata[13] && !tx_full;
  wire tx_pop   = tx_take && !tx_empty;
  wire rx_push  = rx_valid && !rx_full;
  wire rx_pop   = data_wr && wdata[10] && !rx_empty;

  assign tx_valid = !tx_empty;
  assign tx_byte  = tx_mem[tx_rp];
  assign rdata = (rd_en && addr == A_DATA)
    ? {3'b000, tx_full, tx_empty, 1'b0, rx_full, rx_empty, rx_mem[rx_rp]}
    : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tx_mem[i] <= '0;
        rx_mem[i] <= '0;
      end
    end else begin
      if (tx_push) begin
        tx_mem[tx_wp] <= wdata[7:0];
        tx_wp <= tx_wp + 1'b1;
      end
      if (tx_pop) tx_rp <= tx_rp + 1'b1;
      if (tx_push != tx_pop) tx_cnt <= tx_push ? tx_cnt + 1'b1 : tx_cnt - 1'b1;
      if (rx_push) begin
        rx_mem[rx_wp] <= rx_byte;
        rx_wp <= rx_wp + 1'b1;
      end
      if (rx_pop) rx_rp <= rx_rp + 1'b1;
      if (rx_push != rx_pop) rx_cnt <= rx_push ? rx_cnt + 1'b1 : rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_div <= DEF_DIV;
      rx_div <= DEF_DIV;
      frame_cfg <= DEF_FRAME;
    end else if (wr_en) begin
      if (addr == A_TXD) tx_div <= DIV_W'(wdata);
      if (addr == A_RXD) rx_div <= DIV_W'(wdata);
      if (addr == A_CTL) frame_cfg <= wdata[7:0];
    end
  end
endmodule

// File: rtl/uart_fifo_regs_chk.sv
module uart_fifo_regs_chk #(
  parameter int ADDR_W = 16,
  parameter int DIV_W = 16,
  parameter int DEPTH = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'h4000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [15:0]       wdata,
  input logic              tx_valid,
  input logic [7:0]        tx_byte,
  input logic              tx_take,
  input logic              rx_valid,
  input logic [DIV_W-1:0]  tx_div,
  input logic [DIV_W-1:0]  rx_div,
  input logic [$clog2(DEPTH):0] tx_cnt,
  input logic [$clog2(DEPTH):0] rx_cnt
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  wire data_wr = wr_en && addr == BASE + ADDR_W'(1);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULLC && rx_cnt <= FULLC);
  assert_push_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && wdata[13] && !tx_take) |=> tx_valid);
  assert_full_push_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == FULLC && !tx_take) |=> (tx_cnt == FULLC && $stable(tx_byte)));
  assert_empty_pop_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && !rx_valid) |=> rx_cnt == '0);
  assert_txdiv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == BASE + ADDR_W'(2)) |=> $stable(tx_div));
  assert_rxdiv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == BASE + ADDR_W'(3)) |=> $stable(rx_div));
  assert_push_pop_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && wdata[13] && tx_cnt != FULLC && tx_take && tx_cnt != '0)
      |=> $stable(tx_cnt));
endmodule

bind uart_fifo_regs uart_fifo_regs_chk #(
  .ADDR_W(ADDR_W), .DIV_W(DIV_W), .DEPTH(DEPTH), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_take(tx_take),
  .rx_valid(rx_valid), .tx_div(tx_div), .rx_div(rx_div),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/tb_uart_fifo_regs.sv
module tb_uart_fifo_regs;
  localparam logic [15:0] A_DATA = 16'h4001, A_TXD = 16'h4002,
                          A_RXD = 16'h4003, A_CTL = 16'h4004;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, tx_take = 0, rx_valid = 0;
  logic [15:0] addr = 0, wdata = 0, rdata;
  logic [7:0] rx_byte = 0, tx_byte, frame_cfg;
  logic tx_valid;
  logic [15:0] tx_div, rx_div;
  int checks = 0, errors = 0;
  logic [7:0] txq[$], rxq[$];

  always #4 clk = ~clk;

  uart_fifo_regs dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_take(tx_take), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_div(tx_div), .rx_div(rx_div), .frame_cfg(frame_cfg)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_flags();
    logic [15:0] w = 16'h0;
    w[8]  = rxq.size() == 0;
    w[9]  = rxq.size() == DEPTH;
    w[11] = txq.size() == 0;
    w[12] = txq.size() == DEPTH;
    return w;
  endfunction

  task automatic bus_read(input logic [15:0] a, output logic [15:0] v);
    addr = a; rd_en = 1; #1; v = rdata; rd_en = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    wr_en = 0; tx_take = 0; rx_valid = 0;
  endtask

  // one cycle: optional data write with strobes, serializer take, deserializer arrival
  task automatic step(input bit wr, input logic [15:0] d, input bit take,
                      input bit rxv, input logic [7:0] rb);
    bit push = wr && d[13] && txq.size() < DEPTH;
    bit tpop = take && txq.size() > 0;
    bit rpush = rxv && rxq.size() < DEPTH;
    bit rpop = wr && d[10] && rxq.size() > 0;
    wr_en = wr; addr = A_DATA; wdata = d; tx_take = take; rx_valid = rxv; rx_byte = rb;
    tick();
    if (tpop) void'(txq.pop_front());
    if (push) txq.push_back(d[7:0]);
    if (rpop) void'(rxq.pop_front());
    if (rpush) rxq.push_back(rb);
  endtask

  task automatic cfg_write(input logic [15:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d; tick();
  endtask

  task automatic check_state(string req);
    logic [15:0] v;
    bus_read(A_DATA, v);
    check(req, {16'h0, v[15:8], 8'h0}, {16'h0, exp_flags()});
    if (rxq.size() > 0) check(req, v[7:0], rxq[0]);
    check(req, tx_valid, txq.size() > 0);
    if (txq.size() > 0) check(req, tx_byte, txq[0]);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    int unsigned seed = 32'd20250611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_read(A_DATA, v);
    check("R1 status", v, 16'h0900);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 tx_div", tx_div, 16'd1085);
    check("R1 rx_div", rx_div, 16'd1085);
    check("R1 frame", frame_cfg, 8'h84);

    // R8 independent divisors, R9 framing, R10 reads zero
    cfg_write(A_TXD, 16'h0010);
    check("R8 tx_div", tx_div, 16'h0010);
    check("R8 rx_div kept", rx_div, 16'd1085);
    cfg_write(A_RXD, 16'h0020);
    check("R8 rx_div", rx_div, 16'h0020);
    check("R8 tx_div kept", tx_div, 16'h0010);
    cfg_write(A_CTL, 16'hFFB3);
    check("R9 frame", frame_cfg, 8'hB3);
    bus_read(A_TXD, v); check("R10 txdiv read", v, 0);
    bus_read(A_RXD, v); check("R10 rxdiv read", v, 0);
    bus_read(A_CTL, v); check("R10 ctl read", v, 0);

    // R7 status visible next cycle; R3 push; R4 push when full ignored
    step(1, 16'h2011, 0, 0, 0);
    bus_read(A_DATA, v);
    check("R7 tx not empty next cycle", v[11], 0);
    check("R3 tx_byte", tx_byte, 8'h11);
    for (int i = 1; i < DEPTH + 1; i++) step(1, 16'h2000 | 16'(8'h11 + i), 0, 0, 0);
    bus_read(A_DATA, v);
    check("R4 tx full", v[12], 1);
    check("R4 overflow byte dropped", txq.size(), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      check("R3 order", tx_byte, 8'h11 + i);
      step(0, 0, 1, 0, 0);
    end
    check("R3 drained", tx_valid, 0);

    // R5 receive fill, full, drop, ordered pops; R2 layout
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 1, 8'hA0 + 8'(i));
    bus_read(A_DATA, v);
    check("R5 rx full", v, 16'h0AA0);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(A_DATA, v);
      check("R5 rx order", v[7:0], 8'hA0 + 8'(i));
      step(1, 16'h0400, 0, 0, 0);
    end
    bus_read(A_DATA, v);
    check("R2 empty layout", v[15:8], 8'h09);

    // R6 pop when empty
    step(1, 16'h0400, 0, 0, 0);
    bus_read(A_DATA, v2);
    check("R6 pop empty ignored", v2, v);

    // R11 push and take together with one entry
    step(1, 16'h2055, 0, 0, 0);
    step(1, 16'h2066, 1, 0, 0);
    check("R11 tx level kept", txq.size(), 1);
    check_state("R11 tx head");
    step(0, 0, 1, 0, 0);

    // random mix: R2 R3 R5 R7 R11
    for (int n = 0; n < 400; n++) begin
      logic [15:0] d = 16'($urandom) & 16'h24FF;
      step(($urandom % 3) != 0, d, ($urandom % 3) == 0, ($urandom % 2) == 0,
           8'($urandom));
      check_state("R2 R11 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule